// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port memory and watches the selection and address of both ports. Each port is selected by an active-low enable and carries an 11-bit word address, so 2048 locations. When both ports are selected on the same location, one of them is held off. The arbiter drives an active-low busy flag to the port that loses and only to that port. It also qualifies each port's write request, so a write from a losing port never reaches the array.

Arrival order is measured in clock cycles. A port is *settled* in a cycle if it was selected with the same address in that cycle and in the previous one. When contention first appears, a settled port arrived earlier and keeps access, and a port that has just been selected or has just moved its address is the late one. If neither port is settled, or both are, the left port wins the tie. Once a winner is chosen it keeps access until the contention ends.

The control is a three-state machine. In `ST_FREE` neither flag is low. In `ST_LEFT_WINS` the right flag is low, and in `ST_RIGHT_WINS` the left flag is low. There are four transitions. *Claim-left* goes from ST_FREE to ST_LEFT_WINS when contention starts and the right port is not the only settled one. *Claim-right* goes from ST_FREE to ST_RIGHT_WINS when contention starts and only the right port is settled. *Release* goes from either owning state back to ST_FREE when contention ends. *Hold* keeps an owning state while contention lasts.

Top module: `dpa_contention_arb`

## Requirements
- R1: While `rst` is high and on the first edge with it high, both busy flags are driven high (1) and the machine returns to ST_FREE.
- R2: If either enable is high (1 = deselected) or the two addresses differ, both busy flags are high one clock later.
- R3: If contention starts while exactly one port is settled, the other port's busy flag goes low on the next clock.
- R4: If contention starts with neither port settled, the right busy flag goes low and the left one stays high on the next clock.
- R5: The two busy flags are never low together.
- R6: While contention lasts, the port that won keeps access, even if both addresses move together to a new common location.
- R7: The busy flag returns high on the clock after the addresses stop matching or either enable goes high.
- R8: `x_wr_ok` is combinational and equals `x_wr_req` AND port x selected AND port x not losing in the next state. A losing port's write is blocked in the same cycle in which it is judged.
- R9: All 11 address bits are compared. Addresses that differ only in bit 10 do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en_n | input | 1 | Left port select, active low |
| l_addr | input | 11 | Left port word address |
| l_wr_req | input | 1 | Left port write attempt, active high |
| r_en_n | input | 1 | Right port select, active low |
| r_addr | input | 11 | Right port word address |
| r_wr_req | input | 1 | Right port write attempt, active high |
| l_busy_n | output | 1 | Left busy flag, registered, active low |
| r_busy_n | output | 1 | Right busy flag, registered, active low |
| l_wr_ok | output | 1 | Qualified left write, active high |
| r_wr_ok | output | 1 | Qualified right write, active high |

## Verification
The busy flags are due one clock after the inputs that cause them. The bench drives each vector on a falling edge and reads the flags on the following falling edge, so exactly one rising edge lies between stimulus and sample. The write qualifiers are combinational and have no latency. They are read one time unit after the vector is driven, before the rising edge that would commit the next state. The settled marker needs one cycle of history, so the vectors are ordered so that each port's previous cycle is known when the arrival order is predicted.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int NPORTS = 2;
    localparam int PORT_L = 0;
    localparam int PORT_R = 1;

    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_LEFT_WINS  = 2'd1,
        ST_RIGHT_WINS = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic              settled
);
    logic [ADDR_W-1:0] prev_addr;
    logic              prev_act;

    assign active = ~en_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= '0;
            prev_act  <= 1'b0;
        end else begin
            prev_addr <= addr;
            prev_act  <= ~en_n;
        end
    end

    // stable-since marker: selected now and last cycle on the same word
    assign settled = active & prev_act & (addr == prev_addr);
endmodule

// File: rtl/dpa_addr_match.sv
module dpa_addr_match #(
    parameter int ADDR_W = 11
) (
    input  logic              l_act,
    input  logic              r_act,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              contend
);
    logic [ADDR_W-1:0] bit_eq;

    for (genvar bi = 0; bi < ADDR_W; bi++) begin : g_bit
        assign bit_eq[bi] = ~(l_addr[bi] ^ r_addr[bi]);
    end

    assign contend = l_act & r_act & (&bit_eq);
endmodule

// File: rtl/dpa_arb_fsm.sv
module dpa_arb_fsm
    import dpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       contend,
    input  logic       l_settled,
    input  logic       r_settled,
    output arb_state_t state,
    output logic       busy_l_n,
    output logic       busy_r_n,
    output logic       lose_l_nxt,
    output logic       lose_r_nxt
);
    arb_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FREE: begin
                if (contend) begin
                    if (r_settled && !l_settled) state_nxt = ST_RIGHT_WINS;
                    else                         state_nxt = ST_LEFT_WINS;
                end
            end
            ST_LEFT_WINS, ST_RIGHT_WINS: begin
                if (!contend) state_nxt = ST_FREE;
            end
            default: state_nxt = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FREE;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_l_n <= 1'b1;
            busy_r_n <= 1'b1;
        end else begin
            busy_l_n <= (state_nxt != ST_RIGHT_WINS);
            busy_r_n <= (state_nxt != ST_LEFT_WINS);
        end
    end

    assign lose_l_nxt = (state_nxt == ST_RIGHT_WINS);
    assign lose_r_nxt = (state_nxt == ST_LEFT_WINS);

    // R1
    reset_free_chk: assert property (@(posedge clk) rst |=> (state == ST_FREE && busy_l_n && busy_r_n));

    // R6
    hold_left_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LEFT_WINS && contend) |=> (state == ST_LEFT_WINS && !busy_r_n));
endmodule

// File: rtl/dpa_contention_arb.sv
module dpa_contention_arb
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_en_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr_req,
    input  logic              r_en_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr_req,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic [NPORTS-1:0] en_n_v;
    logic [ADDR_W-1:0] addr_v [NPORTS];
    logic [NPORTS-1:0] act_v;
    logic [NPORTS-1:0] settled_v;
    logic              contend;
    logic              lose_l_nxt;
    logic              lose_r_nxt;
    arb_state_t        state;

    assign en_n_v[PORT_L] = l_en_n;
    assign en_n_v[PORT_R] = r_en_n;
    assign addr_v[PORT_L] = l_addr;
    assign addr_v[PORT_R] = r_addr;

    for (genvar pi = 0; pi < NPORTS; pi++) begin : g_port
        dpa_port_track #(.ADDR_W(ADDR_W)) trk_i (
            .clk     (clk),
            .rst     (rst),
            .en_n    (en_n_v[pi]),
            .addr    (addr_v[pi]),
            .active  (act_v[pi]),
            .settled (settled_v[pi])
        );
    end

    dpa_addr_match #(.ADDR_W(ADDR_W)) cmp_i (
        .l_act   (act_v[PORT_L]),
        .r_act   (act_v[PORT_R]),
        .l_addr  (l_addr),
        .r_addr  (r_addr),
        .contend (contend)
    );

    dpa_arb_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .contend    (contend),
        .l_settled  (settled_v[PORT_L]),
        .r_settled  (settled_v[PORT_R]),
        .state      (state),
        .busy_l_n   (l_busy_n),
        .busy_r_n   (r_busy_n),
        .lose_l_nxt (lose_l_nxt),
        .lose_r_nxt (lose_r_nxt)
    );

    assign l_wr_ok = l_wr_req & act_v[PORT_L] & ~lose_l_nxt;
    assign r_wr_ok = r_wr_req & act_v[PORT_R] & ~lose_r_nxt;

    // R5
    no_dual_busy_chk: assert property (@(posedge clk) disable iff (rst) !(!l_busy_n && !r_busy_n));

    // R2
    no_match_free_chk: assert property (@(posedge clk) disable iff (rst)
        !contend |=> (l_busy_n && r_busy_n));

    // R3
    late_right_chk: assert property (@(posedge clk) disable iff (rst)
        (l_busy_n && r_busy_n && contend && settled_v[PORT_L] && !settled_v[PORT_R]) |=> !r_busy_n);

    // R3
    late_left_chk: assert property (@(posedge clk) disable iff (rst)
        (l_busy_n && r_busy_n && contend && settled_v[PORT_R] && !settled_v[PORT_L]) |=> !l_busy_n);

    // R4
    tie_left_chk: assert property (@(posedge clk) disable iff (rst)
        (l_busy_n && r_busy_n && contend && !settled_v[PORT_L] && !settled_v[PORT_R]) |=> (l_busy_n && !r_busy_n));

    // R6
    hold_right_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_busy_n && contend) |=> !l_busy_n);

    // R8
    wr_gate_l_chk: assert property (@(posedge clk) disable iff (rst) l_wr_ok |=> l_busy_n);

    // R8
    wr_gate_r_chk: assert property (@(posedge clk) disable iff (rst) r_wr_ok |=> r_busy_n);
endmodule

// File: tb/dpa_contention_arb_tb_top.sv
module dpa_contention_arb_tb_top;
    localparam int ADDR_W = 11;
    localparam int NVEC   = 16;

    // {tag[3:0], l_en_n, l_addr[10:0], r_en_n, r_addr[10:0], exp_lwr, exp_rwr, exp_lbusy, exp_rbusy}
    localparam logic [31:0] VEC [NVEC] = '{
        {4'd2, 1'b1, 11'h005, 1'b1, 11'h005, 4'b0011},
        {4'd2, 1'b0, 11'h005, 1'b1, 11'h005, 4'b1011},
        {4'd3, 1'b0, 11'h005, 1'b0, 11'h005, 4'b1010},
        {4'd6, 1'b0, 11'h005, 1'b0, 11'h005, 4'b1010},
        {4'd7, 1'b0, 11'h005, 1'b0, 11'h006, 4'b1111},
        {4'd3, 1'b0, 11'h006, 1'b0, 11'h006, 4'b0101},
        {4'd7, 1'b1, 11'h006, 1'b0, 11'h006, 4'b0111},
        {4'd2, 1'b1, 11'h000, 1'b1, 11'h000, 4'b0011},
        {4'd4, 1'b0, 11'h100, 1'b0, 11'h100, 4'b1010},
        {4'd7, 1'b0, 11'h100, 1'b1, 11'h100, 4'b1011},
        {4'd9, 1'b0, 11'h400, 1'b0, 11'h000, 4'b1111},
        {4'd3, 1'b0, 11'h400, 1'b0, 11'h400, 4'b1010},
        {4'd6, 1'b0, 11'h7FF, 1'b0, 11'h7FF, 4'b1010},
        {4'd7, 1'b0, 11'h001, 1'b0, 11'h002, 4'b1111},
        {4'd4, 1'b0, 11'h003, 1'b0, 11'h003, 4'b1010},
        {4'd7, 1'b1, 11'h003, 1'b1, 11'h003, 4'b0011}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              l_en_n = 1'b1;
    logic [ADDR_W-1:0] l_addr = '0;
    logic              l_wr_req = 1'b0;
    logic              r_en_n = 1'b1;
    logic [ADDR_W-1:0] r_addr = '0;
    logic              r_wr_req = 1'b0;
    logic              l_busy_n;
    logic              r_busy_n;
    logic              l_wr_ok;
    logic              r_wr_ok;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    dpa_contention_arb #(.ADDR_W(ADDR_W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .l_en_n   (l_en_n),
        .l_addr   (l_addr),
        .l_wr_req (l_wr_req),
        .r_en_n   (r_en_n),
        .r_addr   (r_addr),
        .r_wr_req (r_wr_req),
        .l_busy_n (l_busy_n),
        .r_busy_n (r_busy_n),
        .l_wr_ok  (l_wr_ok),
        .r_wr_ok  (r_wr_ok)
    );

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check2(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset held with both ports on one word
        @(negedge clk);
        l_en_n = 1'b0; l_addr = 11'h055; r_en_n = 1'b0; r_addr = 11'h055;
        l_wr_req = 1'b1; r_wr_req = 1'b1;
        repeat (3) @(negedge clk);
        check2("R1", "busy in reset", {l_busy_n, r_busy_n}, 2'b11);
        rst = 1'b0;
        // R4: neither settled after reset, so left wins the tie
        @(negedge clk);
        check2("R4", "busy after reset tie", {l_busy_n, r_busy_n}, 2'b10);
        check2("R5", "not both low", {l_busy_n | r_busy_n, 1'b1}, 2'b11);

        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] v;
            v = VEC[k];
            l_en_n = v[27]; l_addr = v[26:16]; r_en_n = v[15]; r_addr = v[14:4];
            l_wr_req = 1'b1; r_wr_req = 1'b1;
            #1;
            check2("R8", $sformatf("wr_ok vector %0d (%s)", k, tag_name(v[31:28])),
                   {l_wr_ok, r_wr_ok}, v[3:2]);
            @(negedge clk);
            check2(tag_name(v[31:28]), $sformatf("busy vector %0d", k),
                   {l_busy_n, r_busy_n}, v[1:0]);
            check2("R5", $sformatf("not both low vector %0d", k),
                   {l_busy_n | r_busy_n, 1'b1}, 2'b11);
        end

        // R8: no write request means no qualified write even when winning
        l_en_n = 1'b0; l_addr = 11'h010; r_en_n = 1'b1; l_wr_req = 1'b0; r_wr_req = 1'b1;
        #1;
        check2("R8", "wr_ok with no request", {l_wr_ok, r_wr_ok}, 2'b00);
        @(negedge clk);

        // R3: right settled first, left arrives late
        l_en_n = 1'b1; r_en_n = 1'b0; r_addr = 11'h020; l_wr_req = 1'b1;
        @(negedge clk);
        l_en_n = 1'b0; l_addr = 11'h020;
        #1;
        check2("R8", "late left write blocked", {l_wr_ok, r_wr_ok}, 2'b01);
        @(negedge clk);
        check2("R3", "late left busy", {l_busy_n, r_busy_n}, 2'b01);

        // R1: reset in the middle of contention frees both flags
        rst = 1'b1;
        @(negedge clk);
        check2("R1", "busy after reset mid contention", {l_busy_n, r_busy_n}, 2'b11);
        l_en_n = 1'b1; r_en_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check2("R2", "idle after reset", {l_busy_n, r_busy_n}, 2'b11);

        finish_run();
    end
endmodule